// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This block brings a programmable logic device from power-on to normal operation. It waits in a quiescent state until the core-supply comparator reports a valid level. It then pulses a reset into the configuration latches. Next it walks the non-volatile bit store one word at a time and strobes each word into the latches. On a programmed part it finishes by initialising the user registers and handing the pins over to the loaded configuration.

A three-way device mode drives the pad and test-port controls: quiescent, erased or user. An erased part never enables its outputs. It keeps its pads weakly pulled high and opens the JTAG controller so that programming can go ahead.

A loss of supply at any moment drops the machine straight back to quiescent and clears the loaded flag. When the supply returns, the whole sequence restarts from address zero.

The defaults, 250 words at four clocks each, give about 100 us of load time on a 10 MHz internal oscillator.

Top module: `cfg_load_seq`

## Requirements
- R1: During reset, and while `supply_ok` is low, the outputs are quiescent: `dev_mode` = 2'b00, `io_en` = 0, `pullup_en` = 1, `jtag_en` = 0, `cfg_valid` = 0, and no `latch_rst`, `latch_load`, `reg_init` or `mem_rd_en` pulse occurs.
- R2: When the machine is quiescent and `supply_ok` is sampled high, `latch_rst` is asserted for exactly CLR_CYCLES consecutive cycles, starting in the next cycle, before any store read.
- R3: On a non-erased part the store is read at ascending addresses 0 to ADDR_COUNT-1, and each word lasts CLKS_PER_STROBE cycles. `mem_rd_en` is high in the first cycle of a word. The store returns the word on `mem_rd_data` by the following cycle. `latch_load` is high in the last cycle of the word, with `latch_addr` equal to the address and `latch_data` equal to the returned word.
- R4: One load sequence issues exactly ADDR_COUNT strobes and lasts ADDR_COUNT*CLKS_PER_STROBE cycles.
- R5: `cfg_valid` goes high in the cycle after the last strobe. `reg_init` is then high for exactly INIT_CYCLES cycles.
- R6: Throughout clear, load and init, the pins stay quiescent (as in R1). User mode starts exactly CLR_CYCLES + ADDR_COUNT*CLKS_PER_STROBE + INIT_CYCLES cycles after the cycle in which the supply was sampled high. In user mode, `dev_mode` = 2'b10, `io_en` = 1, `pullup_en` = 0 (pads act as bus-hold) and `jtag_en` = 1.
- R7: If `erased` is high in the last clear cycle, the machine enters erased mode (`dev_mode` = 2'b01) with `jtag_en` = 1, `io_en` = 0 and `pullup_en` = 1. It issues no strobes and no `reg_init`, and `cfg_valid` stays 0.
- R8: When `supply_ok` is sampled low in any state, the next cycle is quiescent (as in R1) with `cfg_valid` = 0.
- R9: After a supply drop, a returning supply restarts the whole sequence: the latch clear comes first, then the read from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Core-supply comparator level, synchronous to clk |
| erased | input | 1 | Bit store holds no user pattern |
| mem_rd_data | input | DATA_W | Word read from the bit store |
| mem_rd_en | output | 1 | Read request to the bit store |
| mem_addr | output | ADDR_W | Bit store read address |
| latch_rst | output | 1 | Clears the configuration latches |
| latch_load | output | 1 | Load strobe for one latch word |
| latch_addr | output | ADDR_W | Latch word selected by the strobe |
| latch_data | output | DATA_W | Word written by the strobe |
| reg_init | output | 1 | Initialise user registers to their preload state |
| cfg_valid | output | 1 | Configuration fully loaded |
| dev_mode | output | 2 | 00 quiescent, 01 erased, 10 user |
| io_en | output | 1 | Pins take their configured behaviour |
| pullup_en | output | 1 | 1: weak pull-up on pads, 0: bus-hold |
| jtag_en | output | 1 | JTAG controller enabled |

## Verification
The bench builds the sequencer with six words of three clocks each, a two-cycle latch clear and a three-cycle register init. This keeps a full load near 25 cycles. The first and last address, the word-boundary rollover and the exact cycle of the hand-over to user mode can therefore all be checked in every run. The shortest legal strobe period of three clocks puts the read, the capture and the strobe in adjacent cycles. The short load lets supply drops be placed in the middle of the load, during init and in user mode, each followed by a full restart.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
// Shared types for the configuration load sequencer.
package cfg_load_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_QUIET  = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_INIT   = 3'd3,
        ST_USER   = 3'd4,
        ST_ERASED = 3'd5
    } seq_state_e;

    // Device mode seen by the pads and the test port.
    typedef enum logic [1:0] {
        MODE_QUIESCENT = 2'b00,
        MODE_ERASED    = 2'b01,
        MODE_USER      = 2'b10
    } dev_mode_e;

endpackage

// File: rtl/cls_phase_ctrl.sv
`timescale 1ns/1ps
// Phase controller: walks quiescent -> clear -> load -> init -> user
// (or clear -> erased) and holds the loaded flag.
// Assumes supply_ok is already synchronous to clk, and that CLR_CYCLES
// and INIT_CYCLES are at least 1.
module cls_phase_ctrl
    import cfg_load_pkg::*;
#(
    parameter int CLR_CYCLES  = 4,
    parameter int INIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       erased,
    input  logic       load_done,
    output seq_state_e state,
    output logic       latch_rst,
    output logic       reg_init,
    output logic       load_active,
    output logic       cfg_valid
);
    localparam int TMR_MAX = (CLR_CYCLES > INIT_CYCLES) ? CLR_CYCLES : INIT_CYCLES;
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] CLR_LAST  = TW'(CLR_CYCLES - 1);
    localparam logic [TW-1:0] INIT_LAST = TW'(INIT_CYCLES - 1);

    logic [TW-1:0] tmr;

    // Phase register, phase timer and loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            state     <= ST_QUIET;
            tmr       <= '0;
            cfg_valid <= 1'b0;
        end else begin
            case (state)
                ST_QUIET: begin
                    state <= ST_CLEAR;
                    tmr   <= '0;
                end
                ST_CLEAR: begin
                    cfg_valid <= 1'b0;
                    if (tmr == CLR_LAST) begin
                        tmr   <= '0;
                        state <= erased ? ST_ERASED : ST_LOAD;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (load_done) begin
                        state     <= ST_INIT;
                        tmr       <= '0;
                        cfg_valid <= 1'b1;
                    end
                end
                ST_INIT: begin
                    if (tmr == INIT_LAST) begin
                        tmr   <= '0;
                        state <= ST_USER;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Phase strobes decoded from the phase register.
    always_comb begin
        latch_rst   = (state == ST_CLEAR);
        reg_init    = (state == ST_INIT);
        load_active = (state == ST_LOAD);
    end

    assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state == ST_QUIET && !cfg_valid));

    assert_erased_unloaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASED) |-> !cfg_valid);

    assert_init_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_init) |-> cfg_valid);

endmodule

// File: rtl/cls_word_stepper.sv
`timescale 1ns/1ps
// Word stepper: while active, reads one store word every CLKS_PER_STROBE
// cycles and strobes it into the latches in the last cycle of the word.
// Assumes a store with one cycle of read latency, CLKS_PER_STROBE >= 3
// and ADDR_COUNT >= 2.
module cls_word_stepper #(
    parameter int ADDR_COUNT      = 250,
    parameter int CLKS_PER_STROBE = 4,
    parameter int DATA_W          = 16,
    localparam int ADDR_W         = $clog2(ADDR_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              latch_load,
    output logic [ADDR_W-1:0] latch_addr,
    output logic [DATA_W-1:0] latch_data,
    output logic              load_done
);
    localparam int SW = $clog2(CLKS_PER_STROBE);
    localparam logic [SW-1:0]     SUB_LAST  = SW'(CLKS_PER_STROBE - 1);
    localparam logic [SW-1:0]     SUB_CAPT  = SW'(1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(ADDR_COUNT - 1);

    logic [ADDR_W-1:0] addr;
    logic [SW-1:0]     sub;
    logic [DATA_W-1:0] data_q;

    // Address and in-word cycle counters, cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            addr <= '0;
            sub  <= '0;
        end else if (sub == SUB_LAST) begin
            sub  <= '0;
            addr <= (addr == ADDR_LAST) ? '0 : addr + 1'b1;
        end else begin
            sub <= sub + 1'b1;
        end
    end

    // Capture the store word one cycle after the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (active && sub == SUB_CAPT) begin
            data_q <= mem_rd_data;
        end
    end

    // Read request, load strobe and end-of-load decode.
    always_comb begin
        mem_rd_en  = active && (sub == '0);
        mem_addr   = addr;
        latch_load = active && (sub == SUB_LAST);
        latch_addr = addr;
        latch_data = data_q;
        load_done  = latch_load && (addr == ADDR_LAST);
    end

    assert_strobe_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_load |-> (latch_addr <= ADDR_LAST));

    assert_addr_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_load && !load_done) |=> (!active || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_read_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !latch_load);

endmodule

// File: rtl/cls_pin_mode.sv
`timescale 1ns/1ps
// Pin mode decoder: maps the sequencer phase onto the device mode, the
// pad output enable, the pull-up / bus-hold select and the JTAG enable.
module cls_pin_mode
    import cfg_load_pkg::*;
(
    input  seq_state_e state,
    output dev_mode_e  mode,
    output logic       io_en,
    output logic       pullup_en,
    output logic       jtag_en
);
    // Phase to pad and test-port controls.
    always_comb begin
        mode      = MODE_QUIESCENT;
        io_en     = 1'b0;
        pullup_en = 1'b1;
        jtag_en   = 1'b0;
        case (state)
            ST_USER: begin
                mode      = MODE_USER;
                io_en     = 1'b1;
                pullup_en = 1'b0;
                jtag_en   = 1'b1;
            end
            ST_ERASED: begin
                mode    = MODE_ERASED;
                jtag_en = 1'b1;
            end
            default: mode = MODE_QUIESCENT;
        endcase
    end
endmodule

// File: rtl/cfg_load_seq.sv
`timescale 1ns/1ps
// Power-up configuration load sequencer top: phase controller, word
// stepper and pin mode decoder. Assumes supply_ok is synchronous to clk.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int ADDR_COUNT      = 250,
    parameter int CLKS_PER_STROBE = 4,
    parameter int CLR_CYCLES      = 4,
    parameter int INIT_CYCLES     = 8,
    parameter int DATA_W          = 16,
    localparam int ADDR_W         = $clog2(ADDR_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              erased,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              latch_rst,
    output logic              latch_load,
    output logic [ADDR_W-1:0] latch_addr,
    output logic [DATA_W-1:0] latch_data,
    output logic              reg_init,
    output logic              cfg_valid,
    output logic [1:0]        dev_mode,
    output logic              io_en,
    output logic              pullup_en,
    output logic              jtag_en
);
    seq_state_e state;
    dev_mode_e  mode;
    logic       load_active;
    logic       load_done;

    cls_phase_ctrl #(
        .CLR_CYCLES (CLR_CYCLES),
        .INIT_CYCLES(INIT_CYCLES)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .erased     (erased),
        .load_done  (load_done),
        .state      (state),
        .latch_rst  (latch_rst),
        .reg_init   (reg_init),
        .load_active(load_active),
        .cfg_valid  (cfg_valid)
    );

    cls_word_stepper #(
        .ADDR_COUNT     (ADDR_COUNT),
        .CLKS_PER_STROBE(CLKS_PER_STROBE),
        .DATA_W         (DATA_W)
    ) i_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (load_active),
        .mem_rd_data(mem_rd_data),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .latch_load (latch_load),
        .latch_addr (latch_addr),
        .latch_data (latch_data),
        .load_done  (load_done)
    );

    cls_pin_mode i_pins (
        .state    (state),
        .mode     (mode),
        .io_en    (io_en),
        .pullup_en(pullup_en),
        .jtag_en  (jtag_en)
    );

    assign dev_mode = mode;

    assert_io_needs_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> cfg_valid);

    assert_pins_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rst || latch_load || reg_init) |-> (!io_en && !jtag_en && pullup_en));

    assert_drop_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!io_en && !jtag_en && !latch_load && !mem_rd_en));

endmodule

// File: tb/test_cfg_load_seq.sv
`timescale 1ns/1ps
// Directed bench for the configuration load sequencer.
module test_cfg_load_seq;
    localparam int N    = 6;
    localparam int K    = 3;
    localparam int CLR  = 2;
    localparam int INIT = 3;
    localparam int DW   = 8;
    localparam int AW   = $clog2(N);
    localparam int T_TOTAL = CLR + N * K + INIT;

    logic          clk = 1'b0;
    logic          rst_n, supply_ok, erased;
    logic [DW-1:0] mem_rd_data;
    logic          mem_rd_en, latch_rst, latch_load, reg_init, cfg_valid;
    logic [AW-1:0] mem_addr, latch_addr;
    logic [DW-1:0] latch_data;
    logic [1:0]    dev_mode;
    logic          io_en, pullup_en, jtag_en;

    int n_cmp = 0;
    int n_mis = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
        return DW'(a) * 8'd37 ^ 8'h5A;
    endfunction

    // Bit store model: word available as long as the address is held.
    assign mem_rd_data = word_of(mem_addr);

    cfg_load_seq #(
        .ADDR_COUNT(N), .CLKS_PER_STROBE(K), .CLR_CYCLES(CLR),
        .INIT_CYCLES(INIT), .DATA_W(DW)
    ) i_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .erased(erased),
        .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .latch_rst(latch_rst), .latch_load(latch_load), .latch_addr(latch_addr),
        .latch_data(latch_data), .reg_init(reg_init), .cfg_valid(cfg_valid),
        .dev_mode(dev_mode), .io_en(io_en), .pullup_en(pullup_en), .jtag_en(jtag_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Quiescent pin state, used by R1 and R8.
    task automatic check_quiet(string req);
        check({req, " mode"}, 32'(dev_mode), 32'h0);
        check({req, " io_en"}, 32'(io_en), 32'h0);
        check({req, " pullup"}, 32'(pullup_en), 32'h1);
        check({req, " jtag"}, 32'(jtag_en), 32'h0);
        check({req, " valid"}, 32'(cfg_valid), 32'h0);
        check({req, " strobes"}, 32'({latch_rst, latch_load, reg_init, mem_rd_en}), 32'h0);
    endtask

    // R1: reset state, and the supply held low after reset.
    task automatic t_reset();
        rst_n = 1'b0; supply_ok = 1'b1; erased = 1'b0;
        repeat (3) @(negedge clk);
        check_quiet("R1 in reset");
        supply_ok = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_quiet("R1 supply low");
    endtask

    // R2..R7, R9: raise the supply and follow the sequence to its end mode.
    task automatic t_load(bit exp_erased);
        int cyc = 0, n_rst = 0, n_stb = 0, n_init = 0, n_rd = 0;
        bit pins_bad = 0, order_bad = 0;
        supply_ok = 1'b1;
        forever begin
            @(negedge clk);
            if (dev_mode != 2'b00 || cyc > 200) break;
            cyc++;
            if (io_en || jtag_en || !pullup_en) pins_bad = 1;
            if (latch_rst) begin
                n_rst++;
                if (cyc > CLR || n_rd != 0) order_bad = 1;
            end
            if (mem_rd_en) n_rd++;
            if (latch_load) begin
                check("R3 strobe addr", 32'(latch_addr), 32'(n_stb));
                check("R3 strobe data", 32'(latch_data), 32'(word_of(AW'(n_stb))));
                check("R3 strobe cycle", 32'(cyc), 32'(CLR + (n_stb + 1) * K));
                n_stb++;
            end
            if (reg_init) begin
                n_init++;
                if (!cfg_valid) order_bad = 1;
            end
            if (!reg_init && cfg_valid) order_bad = 1;
        end
        check("R2 clear length", 32'(n_rst), 32'(CLR));
        check("R2/R9 clear first", 32'(order_bad), 32'h0);
        check("R6 pins held", 32'(pins_bad), 32'h0);
        if (!exp_erased) begin
            check("R4 strobe count", 32'(n_stb), 32'(N));
            check("R4 read count", 32'(n_rd), 32'(N));
            check("R5 init length", 32'(n_init), 32'(INIT));
            check("R6 user start", 32'(cyc), 32'(T_TOTAL));
            check("R6 mode", 32'(dev_mode), 32'h2);
            check("R6 pins", 32'({io_en, pullup_en, jtag_en}), 32'b101);
            check("R5 valid", 32'(cfg_valid), 32'h1);
        end else begin
            check("R7 erased start", 32'(cyc), 32'(CLR));
            check("R7 mode", 32'(dev_mode), 32'h1);
            check("R7 pins", 32'({io_en, pullup_en, jtag_en}), 32'b011);
            repeat (N * K + INIT + 2) begin
                @(negedge clk);
                if (latch_load || reg_init || mem_rd_en || cfg_valid || io_en) pins_bad = 1;
            end
            check("R7 stays idle", 32'(pins_bad), 32'h0);
            check("R7 mode held", 32'(dev_mode), 32'h1);
        end
    endtask

    // R8: drop the supply after the given number of cycles, then restart (R9).
    task automatic t_drop(int after);
        supply_ok = 1'b1;
        repeat (after) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check_quiet("R8 after drop");
        repeat (3) @(negedge clk);
        check_quiet("R8 held low");
        t_load(1'b0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load(1'b0);
        // Drop from user mode, then a full reload from address 0 (R9).
        supply_ok = 1'b0;
        @(negedge clk);
        check_quiet("R8 from user");
        repeat (2) @(negedge clk);
        t_load(1'b0);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        t_drop(CLR + 4);            // mid-load
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        t_drop(CLR + N * K + 1);    // during init
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        t_drop(1);                  // during clear
        supply_ok = 1'b0;
        erased = 1'b1;
        repeat (2) @(negedge clk);
        t_load(1'b1);
        supply_ok = 1'b0;
        @(negedge clk);
        check_quiet("R8 from erased");
        erased = 1'b0;
        @(negedge clk);
        t_load(1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule